// File: doc/BRIEF.md
# I/O Translation Control and Fault-Status Register Bank

This block holds the software-visible control and fault state of an I/O address translation unit. A 32-bit, word-addressed read/write port reaches a control word and a fault status word. It also reaches a fault address word, a bank of per-slot bus configuration words, an arbiter enable word and a few plain scratch words. Every write is masked for its register, and some fields are forced to constants, so that reads return a value whose fixed bits are always present.

The translation datapath reports a failed lookup on a one-cycle fault strobe. The block then builds a fixed status word and latches the faulting address. From the 3-bit range code in the control word, the block decodes where the DMA window starts. The window always ends at the top of the 32-bit space, and its start is driven out on a plain output for the address comparator.

Writes take effect on the rising clock edge while `bus_we` is high. Reads are combinational from `bus_waddr`. The port has no handshake: every access completes in one cycle.

Top module: `io_xlat_regs`

## Requirements
- R1: The control word is at word index 0. A write keeps only bits 0 and 4:2 (mask 0x0000001D). Bits 4:2 hold the range code and are read back unchanged.
- R2: `win_start` equals 0xFF000000 shifted left by the range code. So code 0 gives 0xFF000000 (16MB) and code 7 gives 0x80000000 (2GB). It follows a control write from the cycle after that write's clock edge.
- R3: Bits 31:24 of the control word always read as the `VERSION` parameter, whatever is written.
- R4: The fault status word is at word index 0x400. A write is masked with 0xFF0FFFFF, then bit 23 is forced to 1. The fault address word is at word index 0x401 and stores writes unchanged.
- R5: Four slot configuration words sit at word indices 0x404 to 0x407. Each keeps only bits 0, 1 and 16 (mask 0x00010003). A write to one slot leaves the other slots unchanged.
- R6: The arbiter enable word is at word index 0x800. A write keeps bits 20:16, and bit 3 always reads as 1.
- R7: On a fault strobe, the status word becomes 0xC0820000, which is bits 31, 30, 23 and 17. Bit 18 is also set (0xC0860000) when the faulting access was a read.
- R8: On a fault strobe, the fault address word takes the faulting address.
- R9: After reset, control reads `VERSION`<<24, arbiter enable reads 0x00000008 and fault status reads 0x00800000. All other words read 0, and `win_start` is 0xFF000000.
- R10: Scratch words at word indices 1 to 4 store writes unmasked. Any word index that is not mapped reads 0, and writes to it are ignored.
- R11: If a bus write and a fault strobe reach the status or address word in the same cycle, the fault result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_waddr | input | 12 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| flt_valid | input | 1 | One-cycle strobe: a translation fault occurred |
| flt_rd | input | 1 | The faulting access was a read |
| flt_addr | input | 32 | Address of the faulting access |
| win_start | output | 32 | Lowest address of the DMA window |

## Verification
A wrong mask or a lost forced constant shows on `bus_rdata` as soon as the register is read, in the cycle after its write. That is the first cycle the read data can change. A fault word composed wrongly, or a lost collision priority, shows on the next read of the status word. A range code decoded wrongly changes `win_start` in the cycle after the control write, long before any DMA access would reveal it. Cross-slot corruption shows only when a neighbouring slot is read, so slots are read back after writes to their neighbours.

// File: rtl/io_xlat_pkg.sv
package io_xlat_pkg;
  // word indices
  localparam int unsigned WI_CTRL     = 32'h000;
  localparam int unsigned WI_SPARE_LO = 32'h001;
  localparam int unsigned WI_FSR      = 32'h400;
  localparam int unsigned WI_FAR      = 32'h401;
  localparam int unsigned WI_SLOT0    = 32'h404;
  localparam int unsigned WI_ARB      = 32'h800;

  localparam logic [31:0] CTRL_KEEP = 32'h0000_001D;
  localparam logic [31:0] FSR_KEEP  = 32'hFF0F_FFFF;
  localparam logic [31:0] FSR_FIXED = 32'h0080_0000;
  localparam logic [31:0] SLOT_KEEP = 32'h0001_0003;
  localparam logic [31:0] ARB_KEEP  = 32'h001F_0000;
  localparam logic [31:0] ARB_MID   = 32'h0000_0008;

  localparam logic [31:0] FLT_ERR = 32'h8000_0000;
  localparam logic [31:0] FLT_LE  = 32'h4000_0000;
  localparam logic [31:0] FLT_RD  = 32'h0004_0000;
  localparam logic [31:0] FLT_FAV = 32'h0002_0000;

  function automatic logic [31:0] fault_word(input logic is_rd);
    fault_word = FLT_ERR | FLT_LE | FSR_FIXED | FLT_FAV | (is_rd ? FLT_RD : 32'h0);
  endfunction
endpackage

// File: rtl/xlat_window_dec.sv
module xlat_window_dec #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MIN_LOG2 = 24,
  parameter int unsigned CODE_W   = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [AW-1:0]     start
);
  localparam int unsigned SH_W = $clog2(AW);

  logic [SH_W-1:0] shamt;
  always_comb begin
    shamt = SH_W'(MIN_LOG2) + SH_W'(code);
    start = {AW{1'b1}} << shamt;
  end
endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
  import io_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fsr,
  input  logic        wr_far,
  input  logic [31:0] wdata,
  input  logic        flt_valid,
  input  logic        flt_rd,
  input  logic [31:0] flt_addr,
  output logic [31:0] fsr_q,
  output logic [31:0] far_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= FSR_FIXED;
      far_q <= '0;
    end else begin
      if (flt_valid) begin
        fsr_q <= fault_word(flt_rd);
        far_q <= flt_addr;
      end else begin
        if (wr_fsr) fsr_q <= (wdata & FSR_KEEP) | FSR_FIXED;
        if (wr_far) far_q <= wdata;
      end
    end
  end

  // R7
  fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> fsr_q == ($past(flt_rd) ? 32'hC086_0000 : 32'hC082_0000));

  // R8
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> far_q == $past(flt_addr));

  // R4
  fsr_fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_q[23] && fsr_q[22:20] == 3'b000);
endmodule

// File: rtl/xlat_slot_bank.sv
module xlat_slot_bank
  import io_xlat_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_we,
  input  logic [31:0]                wdata,
  output logic [NUM_SLOTS-1:0][31:0] slot_q
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_we[i]) slot_q[i] <= wdata & SLOT_KEEP;
    end

    // R5
    slot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q[i] & ~SLOT_KEEP) == 32'h0);

    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[i] |=> $stable(slot_q[i]));
  end
endmodule

// File: rtl/io_xlat_regs.sv
module io_xlat_regs
  import io_xlat_pkg::*;
#(
  parameter logic [7:0]  VERSION   = 8'h04,
  parameter int unsigned WADDR_W   = 12,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_SPARE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [WADDR_W-1:0] bus_waddr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               flt_valid,
  input  logic               flt_rd,
  input  logic [31:0]        flt_addr,
  output logic [31:0]        win_start
);
  localparam int unsigned SPARE_HI = WI_SPARE_LO + NUM_SPARE - 1;

  logic [31:0]                widx;
  logic [23:0]                ctrl_lo_q;
  logic [31:0]                arb_q;
  logic [31:0]                spare_q [NUM_SPARE];
  logic [31:0]                fsr_q, far_q;
  logic [NUM_SLOTS-1:0]       slot_we;
  logic [NUM_SLOTS-1:0][31:0] slot_q;
  logic [NUM_SPARE-1:0]       spare_we;

  assign widx = 32'(bus_waddr);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_we
    assign slot_we[i] = bus_we && (widx == WI_SLOT0 + i);
  end
  for (genvar i = 0; i < NUM_SPARE; i++) begin : g_spare
    assign spare_we[i] = bus_we && (widx == WI_SPARE_LO + i);
    always_ff @(posedge clk) begin
      if (!rst_n)           spare_q[i] <= '0;
      else if (spare_we[i]) spare_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_lo_q <= '0;
      arb_q     <= ARB_MID;
    end else if (bus_we) begin
      if (widx == WI_CTRL) ctrl_lo_q <= bus_wdata[23:0] & CTRL_KEEP[23:0];
      if (widx == WI_ARB)  arb_q     <= (bus_wdata & ARB_KEEP) | ARB_MID;
    end
  end

  xlat_fault_unit u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fsr    (bus_we && widx == WI_FSR),
    .wr_far    (bus_we && widx == WI_FAR),
    .wdata     (bus_wdata),
    .flt_valid (flt_valid),
    .flt_rd    (flt_rd),
    .flt_addr  (flt_addr),
    .fsr_q     (fsr_q),
    .far_q     (far_q)
  );

  xlat_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_we (slot_we),
    .wdata   (bus_wdata),
    .slot_q  (slot_q)
  );

  xlat_window_dec #(.AW(32), .MIN_LOG2(24), .CODE_W(3)) u_win (
    .code  (ctrl_lo_q[4:2]),
    .start (win_start)
  );

  always_comb begin
    bus_rdata = '0;
    if (widx == WI_CTRL) bus_rdata = {VERSION, ctrl_lo_q};
    if (widx == WI_FSR)  bus_rdata = fsr_q;
    if (widx == WI_FAR)  bus_rdata = far_q;
    if (widx == WI_ARB)  bus_rdata = arb_q;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (widx == WI_SLOT0 + i) bus_rdata = slot_q[i];
    for (int i = 0; i < NUM_SPARE; i++)
      if (widx == WI_SPARE_LO + i) bus_rdata = spare_q[i];
  end

  // R6
  arb_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_q[3] && (arb_q & ~(ARB_KEEP | ARB_MID)) == 32'h0);

  // R2
  win_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start[23:0] == 24'h0 && win_start[31]);

  // R3
  ctrl_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == WI_CTRL) |-> bus_rdata[31:24] == VERSION);

  // R10
  spare_range_chk: assert final (SPARE_HI < WI_FSR);
endmodule

// File: tb/io_xlat_regs_bench.sv
`timescale 1ns/1ps
module io_xlat_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flt_valid = 1'b0;
  logic        flt_rd = 1'b0;
  logic [31:0] flt_addr = '0;
  logic [31:0] win_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  io_xlat_regs u_io_xlat_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
    .flt_rd(flt_rd), .flt_addr(flt_addr), .win_start(win_start)
  );

  // {word index, write data, expected readback}
  localparam int NV = 12;
  localparam logic [95:0] VEC [NV] = '{
    {32'h000, 32'hFFFF_FFFF, 32'h0400_001D},  // R1 R3
    {32'h000, 32'h0000_0008, 32'h0400_0008},  // R1
    {32'h400, 32'hFFFF_FFFF, 32'hFF8F_FFFF},  // R4
    {32'h400, 32'h0000_0000, 32'h0080_0000},  // R4
    {32'h401, 32'h1234_5678, 32'h1234_5678},  // R4
    {32'h404, 32'hFFFF_FFFF, 32'h0001_0003},  // R5
    {32'h407, 32'h4001_0002, 32'h0001_0002},  // R5
    {32'h405, 32'h0000_0004, 32'h0000_0000},  // R5
    {32'h800, 32'hFFFF_FFFF, 32'h001F_0008},  // R6
    {32'h800, 32'h0000_0000, 32'h0000_0008},  // R6
    {32'h002, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R10
    {32'hC00, 32'h0000_0055, 32'h0000_0000}   // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_waddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fault(input logic r, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1'b1; flt_rd = r; flt_addr = a;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values
    rd(12'h000, v); check("R9 ctrl", v, 32'h0400_0000);
    rd(12'h800, v); check("R9 arb", v, 32'h0000_0008);
    rd(12'h400, v); check("R9 fsr", v, 32'h0080_0000);
    rd(12'h401, v); check("R9 far", v, 32'h0);
    rd(12'h406, v); check("R9 slot", v, 32'h0);
    rd(12'h001, v); check("R9 spare", v, 32'h0);
    check("R9 win_start", win_start, 32'hFF00_0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v);
      check("table", v, VEC[i][31:0]);
    end

    // R5 neighbours kept
    rd(12'h404, v); check("R5 slot0 kept", v, 32'h0001_0003);
    rd(12'h406, v); check("R5 slot2 untouched", v, 32'h0);

    // R2 window sweep
    for (int c = 0; c < 8; c++) begin
      wr(12'h000, 32'(c) << 2);
      check("R2 win_start", win_start, 32'hFF00_0000 << c);
    end
    wr(12'h000, 32'h0000_001F);
    rd(12'h000, v); check("R3 ctrl version", v, 32'h0400_001D);

    // R7 R8 faults
    fault(1'b1, 32'hCAFE_0000);
    rd(12'h400, v); check("R7 read fault", v, 32'hC086_0000);
    rd(12'h401, v); check("R8 fault addr", v, 32'hCAFE_0000);
    fault(1'b0, 32'h8000_1234);
    rd(12'h400, v); check("R7 write fault", v, 32'hC082_0000);
    rd(12'h401, v); check("R8 fault addr 2", v, 32'h8000_1234);

    // R11 collision
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = 12'h400; bus_wdata = 32'h0;
    flt_valid = 1'b1; flt_rd = 1'b0; flt_addr = 32'h9000_0000;
    @(negedge clk);
    bus_we = 1'b0; flt_valid = 1'b0;
    rd(12'h400, v); check("R11 fault wins fsr", v, 32'hC082_0000);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = 12'h401; bus_wdata = 32'h1111_1111;
    flt_valid = 1'b1; flt_rd = 1'b1; flt_addr = 32'hA000_0000;
    @(negedge clk);
    bus_we = 1'b0; flt_valid = 1'b0;
    rd(12'h401, v); check("R11 fault wins far", v, 32'hA000_0000);

    // R9 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h400, v); check("R9 fsr after reset", v, 32'h0080_0000);
    check("R9 win after reset", win_start, 32'hFF00_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule